// File: doc/BRIEF.md
# Execution Unit Occupancy Tracker

This block keeps a cycle-accurate picture of which execution stages of a superscalar core hold an operation. An issue request presents a tag, an operation class, up to three per-stage cycle counts and the source and destination register numbers. The tracker answers in the same cycle whether the request may issue. On an accepted request it places the operation in the entry stage of its unit at the next clock edge. It then counts down each stage's remaining cycles, moves operations along the three-stage floating-point pipe and the two-stage load/store pipe, and reports every completion with its tag.

The tracked resources are:
- two interchangeable single-cycle integer units, guarded by a same-cycle register dependency interlock;
- one multi-cycle integer unit;
- a three-stage floating-point pipe, which divides leave from the first stage;
- a two-stage load/store pipe;
- a branch unit.

A scheduler drives the request port. A separate completion buffer supplies a ready flag, and no request issues while that flag is low.

Top module: `exu_occupancy`

## Requirements
- R1: Synchronous reset empties every stage and clears all completion outputs. Right after reset, any defined class is accepted.
- R2: While `cbuf_ready` is 0, no request is accepted, whatever the state of the units.
- R3: Class codes are 0 simple integer, 1 complex integer, 2 floating, 3 floating divide, 4 load/store, 5 branch. A simple request is accepted when both single-cycle units are empty. It is refused when both are occupied.
- R4: When exactly one single-cycle unit is occupied, a simple request is refused if either of its source registers equals the destination register of the occupying operation.
- R5: When exactly one single-cycle unit is occupied, a simple request is also refused if either source equals the destination of an operation that a single-cycle unit completed at the preceding clock edge. One cycle later that record no longer blocks.
- R6: An accepted simple operation goes to unit 0 (completion index 0) when unit 0 is empty, and otherwise to unit 1 (completion index 1).
- R7: A request of any other class is accepted only when the entry stage of its unit is empty. Class codes 6 and 7 are always refused.
- R8: An operation issued to the complex integer unit or the branch unit, or to either single-cycle unit, with first count N completes N clock edges after its issue edge. A count of 0 behaves as 1.
- R9: Unobstructed, a floating operation with counts a, b, c (each at least 1) completes on index 4 a+b+c edges after issue. A floating divide with count a completes on index 6 after a edges and never occupies the later floating stages.
- R10: Floating stage 2 moves to stage 3 when stage 3 is empty or finishing in the same edge. Stage 1 then moves to stage 2 when stage 2 is empty or moving on in that edge. A blocked operation holds with count 0. On each move the count reloads from the operation's value for the new stage.
- R11: Load/store stage 1 moves to stage 2 under the rule of R10, reloading the second count. Completions appear on index 3.
- R12: Completion index map: 0 and 1 single-cycle units, 2 complex integer, 3 load/store stage 2, 4 floating stage 3, 5 branch, 6 floating divide. Each completion carries its operation's tag in the matching `done_tag` slice. Several indices may fire at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Issue request present |
| iss_class | input | 3 | Operation class code |
| iss_tag | input | TAG_W | Operation tag |
| iss_cyc0 | input | CNT_W | Cycles in the entry stage |
| iss_cyc1 | input | CNT_W | Cycles in the second pipe stage |
| iss_cyc2 | input | CNT_W | Cycles in the third pipe stage |
| iss_src_a | input | REG_W | First source register |
| iss_src_b | input | REG_W | Second source register |
| iss_dst | input | REG_W | Destination register |
| cbuf_ready | input | 1 | Completion buffer has a free entry |
| iss_accept | output | 1 | Request issues at the coming edge |
| done_vld | output | 7 | Completion strobes, one per index |
| done_tag | output | 7*TAG_W | Tags of the completions, index i in slice i |

## Verification
The bench aims at the dual single-cycle interlock. Sources matching the occupant's destination, and sources matching the destination of an operation completed one edge earlier, must be refused. The same source must be accepted a cycle later. A design that forgets the completion record, or keeps it too long, accepts or refuses at the wrong cycle. The floating pipe is driven into back-pressure, with a stage freed and refilled in the same edge. A design with the wrong move order, or one that decrements on the reload cycle, reports completions one or more cycles off. Divides, zero counts and simultaneous completions on several units are checked so that a wrong index or tag, or a divide leaking into later stages, shows up as a missing or extra completion.

// File: rtl/exu_occ_pkg.sv
package exu_occ_pkg;

   parameter int N_STAGE = 9;
   parameter int ST_SI0  = 0;
   parameter int ST_SI1  = 1;
   parameter int ST_CX   = 2;
   parameter int ST_FP1  = 3;
   parameter int ST_FP2  = 4;
   parameter int ST_FP3  = 5;
   parameter int ST_LS1  = 6;
   parameter int ST_LS2  = 7;
   parameter int ST_BR   = 8;

   parameter int N_DONE  = 7;
   parameter int DN_SI0  = 0;
   parameter int DN_SI1  = 1;
   parameter int DN_CX   = 2;
   parameter int DN_LS   = 3;
   parameter int DN_FP   = 4;
   parameter int DN_BR   = 5;
   parameter int DN_DIV  = 6;

   typedef enum logic [2:0] {
      CL_SIMPLE  = 3'd0,
      CL_COMPLEX = 3'd1,
      CL_FLOAT   = 3'd2,
      CL_FDIV    = 3'd3,
      CL_MEM     = 3'd4,
      CL_BRANCH  = 3'd5
   } op_class_e;

   // stage whose tag feeds completion index i
   function automatic int done_src(input int i);
      case (i)
         DN_SI0:  return ST_SI0;
         DN_SI1:  return ST_SI1;
         DN_CX:   return ST_CX;
         DN_LS:   return ST_LS2;
         DN_FP:   return ST_FP3;
         DN_BR:   return ST_BR;
         default: return ST_FP1;
      endcase
   endfunction

   // entry stage for every class except simple integer
   function automatic int entry_stage(input op_class_e c);
      case (c)
         CL_COMPLEX:       return ST_CX;
         CL_FLOAT, CL_FDIV: return ST_FP1;
         CL_MEM:           return ST_LS1;
         CL_BRANCH:        return ST_BR;
         default:          return ST_SI0;
      endcase
   endfunction

endpackage

// File: rtl/exu_stage_slot.sv
module exu_stage_slot #(
   parameter int TAG_W = 6,
   parameter int CNT_W = 6,
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld,
   input  logic             clr,
   input  logic [TAG_W-1:0] ld_tag,
   input  logic [CNT_W-1:0] ld_cnt,
   input  logic [CNT_W-1:0] ld_c1,
   input  logic [CNT_W-1:0] ld_c2,
   input  logic [REG_W-1:0] ld_dst,
   input  logic             ld_div,
   output logic             vld,
   output logic [TAG_W-1:0] tag,
   output logic [CNT_W-1:0] c1,
   output logic [CNT_W-1:0] c2,
   output logic [REG_W-1:0] dst,
   output logic             div,
   output logic             expiring
);

   logic [CNT_W-1:0] cnt;

   // count reaches zero at the coming edge (a held zero stays zero)
   assign expiring = (cnt <= CNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         vld <= 1'b0;
         cnt <= '0;
      end else if (ld) begin
         vld <= 1'b1;
         cnt <= ld_cnt;
         tag <= ld_tag;
         c1  <= ld_c1;
         c2  <= ld_c2;
         dst <= ld_dst;
         div <= ld_div;
      end else begin
         if (clr) vld <= 1'b0;
         if (vld && cnt != '0) cnt <= cnt - CNT_W'(1);
      end
   end

endmodule

// File: rtl/exu_issue_gate.sv
module exu_issue_gate
   import exu_occ_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic               iss_valid,
   input  op_class_e          iss_class,
   input  logic [REG_W-1:0]   src_a,
   input  logic [REG_W-1:0]   src_b,
   input  logic               cbuf_ready,
   input  logic [N_STAGE-1:0] busy,
   input  logic [REG_W-1:0]   occ_dst0,
   input  logic [REG_W-1:0]   occ_dst1,
   input  logic [1:0]         rec_vld,
   input  logic [REG_W-1:0]   rec_dst0,
   input  logic [REG_W-1:0]   rec_dst1,
   output logic               accept,
   output logic [N_STAGE-1:0] tgt
);

   logic             ok;
   logic [REG_W-1:0] occ;
   logic             hit;

   function automatic logic reads(input logic [REG_W-1:0] r,
                                  input logic [REG_W-1:0] a,
                                  input logic [REG_W-1:0] b);
      return (a == r) || (b == r);
   endfunction

   always_comb begin
      ok  = 1'b0;
      tgt = '0;
      occ = busy[ST_SI0] ? occ_dst0 : occ_dst1;
      hit = reads(occ, src_a, src_b)
          | (rec_vld[0] && reads(rec_dst0, src_a, src_b))
          | (rec_vld[1] && reads(rec_dst1, src_a, src_b));
      case (iss_class)
         CL_SIMPLE: begin
            if (!busy[ST_SI0] && !busy[ST_SI1]) begin
               ok = 1'b1;
               tgt[ST_SI0] = 1'b1;
            end else if (!(busy[ST_SI0] && busy[ST_SI1])) begin
               ok = !hit;
               if (busy[ST_SI0]) tgt[ST_SI1] = 1'b1;
               else              tgt[ST_SI0] = 1'b1;
            end
         end
         CL_COMPLEX, CL_FLOAT, CL_FDIV, CL_MEM, CL_BRANCH: begin
            ok = !busy[entry_stage(iss_class)];
            tgt[entry_stage(iss_class)] = 1'b1;
         end
         default: ok = 1'b0;
      endcase
      accept = iss_valid && cbuf_ready && ok;
   end

endmodule

// File: rtl/exu_occupancy.sv
module exu_occupancy
   import exu_occ_pkg::*;
#(
   parameter int TAG_W = 6,
   parameter int CNT_W = 6,
   parameter int REG_W = 5
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    iss_valid,
   input  logic [2:0]              iss_class,
   input  logic [TAG_W-1:0]        iss_tag,
   input  logic [CNT_W-1:0]        iss_cyc0,
   input  logic [CNT_W-1:0]        iss_cyc1,
   input  logic [CNT_W-1:0]        iss_cyc2,
   input  logic [REG_W-1:0]        iss_src_a,
   input  logic [REG_W-1:0]        iss_src_b,
   input  logic [REG_W-1:0]        iss_dst,
   input  logic                    cbuf_ready,
   output logic                    iss_accept,
   output logic [N_DONE-1:0]       done_vld,
   output logic [N_DONE*TAG_W-1:0] done_tag
);

   localparam int DONE_W = N_DONE * TAG_W;

   if (TAG_W < 1) begin : g_bad_tag
      $error("exu_occupancy: TAG_W must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("exu_occupancy: CNT_W must be at least 1");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("exu_occupancy: REG_W must be at least 1");
   end

   op_class_e cls;
   assign cls = op_class_e'(iss_class);

   // stage state
   logic [N_STAGE-1:0] s_vld, s_div, s_exp;
   logic [TAG_W-1:0]   s_tag [N_STAGE];
   logic [CNT_W-1:0]   s_c1  [N_STAGE];
   logic [CNT_W-1:0]   s_c2  [N_STAGE];
   logic [REG_W-1:0]   s_dst [N_STAGE];

   // stage loads
   logic [N_STAGE-1:0] ld, clr, ld_div;
   logic [TAG_W-1:0]   ld_tag [N_STAGE];
   logic [CNT_W-1:0]   ld_cnt [N_STAGE];
   logic [CNT_W-1:0]   ld_c1  [N_STAGE];
   logic [CNT_W-1:0]   ld_c2  [N_STAGE];
   logic [REG_W-1:0]   ld_dst [N_STAGE];

   // completions by the single-cycle units at the last edge
   logic [1:0]         rec_vld;
   logic [REG_W-1:0]   rec_dst0, rec_dst1;

   logic [N_STAGE-1:0] tgt;
   logic [N_DONE-1:0]  fin;
   logic               mv12, mv23, mvls;

   exu_issue_gate #(.REG_W(REG_W)) u_gate (
      .iss_valid (iss_valid),
      .iss_class (cls),
      .src_a     (iss_src_a),
      .src_b     (iss_src_b),
      .cbuf_ready(cbuf_ready),
      .busy      (s_vld),
      .occ_dst0  (s_dst[ST_SI0]),
      .occ_dst1  (s_dst[ST_SI1]),
      .rec_vld   (rec_vld),
      .rec_dst0  (rec_dst0),
      .rec_dst1  (rec_dst1),
      .accept    (iss_accept),
      .tgt       (tgt)
   );

   for (genvar g = 0; g < N_STAGE; g++) begin : g_slot
      exu_stage_slot #(.TAG_W(TAG_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_slot (
         .clk     (clk),
         .rst     (rst),
         .ld      (ld[g]),
         .clr     (clr[g]),
         .ld_tag  (ld_tag[g]),
         .ld_cnt  (ld_cnt[g]),
         .ld_c1   (ld_c1[g]),
         .ld_c2   (ld_c2[g]),
         .ld_dst  (ld_dst[g]),
         .ld_div  (ld_div[g]),
         .vld     (s_vld[g]),
         .tag     (s_tag[g]),
         .c1      (s_c1[g]),
         .c2      (s_c2[g]),
         .dst     (s_dst[g]),
         .div     (s_div[g]),
         .expiring(s_exp[g])
      );
   end

   // finishing and moving decisions; downstream vacancies first
   always_comb begin
      fin[DN_SI0] = s_vld[ST_SI0] && s_exp[ST_SI0];
      fin[DN_SI1] = s_vld[ST_SI1] && s_exp[ST_SI1];
      fin[DN_CX]  = s_vld[ST_CX]  && s_exp[ST_CX];
      fin[DN_LS]  = s_vld[ST_LS2] && s_exp[ST_LS2];
      fin[DN_FP]  = s_vld[ST_FP3] && s_exp[ST_FP3];
      fin[DN_BR]  = s_vld[ST_BR]  && s_exp[ST_BR];
      fin[DN_DIV] = s_vld[ST_FP1] && s_exp[ST_FP1] && s_div[ST_FP1];
      mv23 = s_vld[ST_FP2] && s_exp[ST_FP2] && (!s_vld[ST_FP3] || fin[DN_FP]);
      mv12 = s_vld[ST_FP1] && s_exp[ST_FP1] && !s_div[ST_FP1]
           && (!s_vld[ST_FP2] || mv23);
      mvls = s_vld[ST_LS1] && s_exp[ST_LS1] && (!s_vld[ST_LS2] || fin[DN_LS]);

      clr = '0;
      clr[ST_SI0] = fin[DN_SI0];
      clr[ST_SI1] = fin[DN_SI1];
      clr[ST_CX]  = fin[DN_CX];
      clr[ST_FP1] = fin[DN_DIV] || mv12;
      clr[ST_FP2] = mv23;
      clr[ST_FP3] = fin[DN_FP];
      clr[ST_LS1] = mvls;
      clr[ST_LS2] = fin[DN_LS];
      clr[ST_BR]  = fin[DN_BR];
   end

   // stage loads: issue into entry stages, moves into later stages
   always_comb begin
      for (int s = 0; s < N_STAGE; s++) begin
         ld[s]     = iss_accept && tgt[s];
         ld_tag[s] = iss_tag;
         ld_cnt[s] = iss_cyc0;
         ld_c1[s]  = iss_cyc1;
         ld_c2[s]  = iss_cyc2;
         ld_dst[s] = iss_dst;
         ld_div[s] = (cls == CL_FDIV);
      end
      ld[ST_FP2]     = mv12;
      ld_tag[ST_FP2] = s_tag[ST_FP1];
      ld_cnt[ST_FP2] = s_c1[ST_FP1];
      ld_c2[ST_FP2]  = s_c2[ST_FP1];
      ld_div[ST_FP2] = 1'b0;
      ld[ST_FP3]     = mv23;
      ld_tag[ST_FP3] = s_tag[ST_FP2];
      ld_cnt[ST_FP3] = s_c2[ST_FP2];
      ld_div[ST_FP3] = 1'b0;
      ld[ST_LS2]     = mvls;
      ld_tag[ST_LS2] = s_tag[ST_LS1];
      ld_cnt[ST_LS2] = s_c1[ST_LS1];
      ld_div[ST_LS2] = 1'b0;
   end

   // completion events and the single-cycle completion record
   always_ff @(posedge clk) begin
      if (rst) begin
         done_vld <= '0;
         rec_vld  <= '0;
      end else begin
         done_vld <= fin;
         rec_vld  <= fin[DN_SI1:DN_SI0];
      end
      rec_dst0 <= s_dst[ST_SI0];
      rec_dst1 <= s_dst[ST_SI1];
   end

   for (genvar i = 0; i < N_DONE; i++) begin : g_done_tag
      always_ff @(posedge clk) begin
         done_tag[i*TAG_W +: TAG_W] <= s_tag[done_src(i)];
      end
   end

   logic unused_ok;
   assign unused_ok = ^{DONE_W[0]};

endmodule

// File: rtl/exu_occupancy_chk.sv
module exu_occupancy_chk
   import exu_occ_pkg::*;
(
   input logic               clk,
   input logic               rst,
   input logic               cbuf_ready,
   input logic               iss_valid,
   input logic [2:0]         iss_class,
   input logic               iss_accept,
   input logic [N_STAGE-1:0] busy,
   input logic [N_DONE-1:0]  done_vld
);

   // R1: the cycle after reset, nothing is held or reported
   a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (busy == '0 && done_vld == '0));

   // R2: no buffer entry, no issue
   a_r2_no_buffer_no_issue: assert property (@(posedge clk) disable iff (rst)
      !cbuf_ready |-> !iss_accept);

   // R3: both single-cycle units occupied refuses simple work
   a_r3_simple_both_busy: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && iss_class == 3'd0 && busy[ST_SI0] && busy[ST_SI1]) |-> !iss_accept);

   // R6: an empty unit 0 receives the simple operation
   a_r6_unit0_first: assert property (@(posedge clk) disable iff (rst)
      (iss_accept && iss_class == 3'd0 && !busy[ST_SI0]) |=> busy[ST_SI0]);

   // R7: complex integer entry stage must be empty to accept
   a_r7_entry_free: assert property (@(posedge clk) disable iff (rst)
      (iss_accept && iss_class == 3'd1) |-> !busy[ST_CX]);

   // R7: undefined classes never issue
   a_r7_bad_class: assert property (@(posedge clk) disable iff (rst)
      (iss_class[2:1] == 2'b11) |-> !iss_accept);

   // R9: a divide completion comes out of the first floating stage
   a_r9_div_from_fp1: assert property (@(posedge clk) disable iff (rst)
      done_vld[DN_DIV] |-> $past(busy[ST_FP1]));

   // R12: a floating completion needs an occupied last floating stage
   a_r12_fp_from_fp3: assert property (@(posedge clk) disable iff (rst)
      done_vld[DN_FP] |-> $past(busy[ST_FP3]));

endmodule

bind exu_occupancy exu_occupancy_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .cbuf_ready(cbuf_ready),
   .iss_valid (iss_valid),
   .iss_class (iss_class),
   .iss_accept(iss_accept),
   .busy      (s_vld),
   .done_vld  (done_vld)
);

// File: tb/sim_exu_occupancy.sv
`timescale 1ns/1ps
module sim_exu_occupancy;

   localparam int TAG_W = 6;
   localparam int CNT_W = 6;
   localparam int REG_W = 5;
   localparam int ND    = 7;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic                iss_valid = 1'b0;
   logic [2:0]          iss_class = '0;
   logic [TAG_W-1:0]    iss_tag = '0;
   logic [CNT_W-1:0]    iss_cyc0 = '0, iss_cyc1 = '0, iss_cyc2 = '0;
   logic [REG_W-1:0]    iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
   logic                cbuf_ready = 1'b1;
   logic                iss_accept;
   logic [ND-1:0]       done_vld;
   logic [ND*TAG_W-1:0] done_tag;

   exu_occupancy #(.TAG_W(TAG_W), .CNT_W(CNT_W), .REG_W(REG_W)) u0 (.*);

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    at;
      int    idx;
      int    tag;
      string req;
   } exp_t;
   exp_t sb[$];

   int  vectors = 0;
   int  miscompares = 0;
   bit  finished = 1'b0;
   bit  reported = 1'b0;

   localparam int SIMPLE = 0, COMPLEX = 1, FLT = 2, FDIV = 3, MEM = 4, BR = 5;

   // drive one request at a falling edge; check accept; log expected completion
   task automatic issue(input int cls, input int tag, input int c0, input int c1,
                        input int c2, input int sa, input int sb_, input int d,
                        input bit exp_acc, input int idx, input int lat,
                        input string req);
      @(negedge clk);
      iss_valid = 1'b1;
      iss_class = 3'(cls);
      iss_tag   = TAG_W'(tag);
      iss_cyc0  = CNT_W'(c0);
      iss_cyc1  = CNT_W'(c1);
      iss_cyc2  = CNT_W'(c2);
      iss_src_a = REG_W'(sa);
      iss_src_b = REG_W'(sb_);
      iss_dst   = REG_W'(d);
      #1;
      vectors++;
      if (iss_accept !== exp_acc) begin
         miscompares++;
         $display("FAIL %s: accept of tag %0d is %0b, expected %0b", req, tag, iss_accept, exp_acc);
      end
      if (exp_acc) sb.push_back('{cyc + 1 + lat, idx, tag, req});
      @(posedge clk);
      #1 iss_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: match completions against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (!rst) begin
            for (int i = 0; i < ND; i++) begin
               if (done_vld[i]) begin
                  int tg;
                  int hit;
                  tg  = int'(done_tag[i*TAG_W +: TAG_W]);
                  hit = -1;
                  foreach (sb[k]) if (hit < 0 && sb[k].at == cyc && sb[k].idx == i && sb[k].tag == tg) hit = k;
                  vectors++;
                  if (hit >= 0) sb.delete(hit);
                  else begin
                     miscompares++;
                     $display("FAIL R12: completion idx %0d tag %0d at cycle %0d, expected none", i, tg, cyc);
                  end
               end
            end
            for (int k = sb.size() - 1; k >= 0; k--) begin
               if (sb[k].at < cyc) begin
                  vectors++;
                  miscompares++;
                  $display("FAIL %s: no completion idx %0d tag %0d, expected at cycle %0d", sb[k].req, sb[k].idx, sb[k].tag, sb[k].at);
                  sb.delete(k);
               end
            end
         end
      end
   end

   task automatic summary();
      if (!reported) begin
         reported = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      end
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: run hung, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      vectors++;
      if (done_vld !== '0) begin
         miscompares++;
         $display("FAIL R1: done_vld %b after reset, expected 0", done_vld);
      end
      // R1: empty after reset, so a branch issues at once; R8: count 1
      issue(BR, 1, 1, 0, 0, 0, 0, 0, 1, 5, 1, "R1");
      idle(4);

      // R2: no free buffer entry refuses even with all units empty
      cbuf_ready = 1'b0;
      issue(COMPLEX, 2, 1, 0, 0, 0, 0, 0, 0, 2, 1, "R2");
      cbuf_ready = 1'b1;
      idle(3);

      // R3 and R6: unit 0, then unit 1, then both busy
      issue(SIMPLE, 3, 3, 0, 0, 1, 2, 5, 1, 0, 3, "R6");
      issue(SIMPLE, 4, 3, 0, 0, 3, 4, 6, 1, 1, 3, "R6");
      issue(SIMPLE, 5, 3, 0, 0, 8, 9, 12, 0, 0, 0, "R3");
      idle(6);

      // R4: dependency on the occupant's destination
      issue(SIMPLE, 6, 4, 0, 0, 1, 2, 7, 1, 0, 4, "R4");
      issue(SIMPLE, 7, 1, 0, 0, 7, 2, 13, 0, 0, 0, "R4");
      issue(SIMPLE, 8, 1, 0, 0, 3, 7, 13, 0, 0, 0, "R4");
      issue(SIMPLE, 9, 2, 0, 0, 8, 9, 14, 1, 1, 2, "R4");
      idle(6);

      // R5: record of last-edge completion blocks for one cycle only
      issue(SIMPLE, 10, 1, 0, 0, 1, 2, 10, 1, 0, 1, "R5");
      issue(SIMPLE, 11, 5, 0, 0, 1, 2, 11, 1, 1, 5, "R5");
      issue(SIMPLE, 12, 1, 0, 0, 10, 3, 15, 0, 0, 0, "R5");
      issue(SIMPLE, 13, 1, 0, 0, 10, 3, 15, 1, 0, 1, "R5 R6");
      idle(8);

      // R7: entry stage occupancy and undefined classes
      issue(COMPLEX, 14, 6, 0, 0, 0, 0, 0, 1, 2, 6, "R7");
      issue(COMPLEX, 15, 1, 0, 0, 0, 0, 0, 0, 2, 0, "R7");
      issue(BR, 16, 2, 0, 0, 0, 0, 0, 1, 5, 2, "R7");
      issue(BR, 17, 1, 0, 0, 0, 0, 0, 0, 5, 0, "R7");
      issue(6, 18, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      issue(7, 19, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      idle(8);

      // R8: zero count behaves as one
      issue(COMPLEX, 20, 0, 0, 0, 0, 0, 0, 1, 2, 1, "R8");
      idle(4);

      // R12: three units finishing at the same edge
      issue(SIMPLE, 21, 3, 0, 0, 1, 2, 3, 1, 0, 3, "R12");
      issue(COMPLEX, 22, 2, 0, 0, 0, 0, 0, 1, 2, 2, "R12");
      issue(BR, 23, 1, 0, 0, 0, 0, 0, 1, 5, 1, "R12");
      idle(6);

      // R9: unobstructed floating pipe and divide
      issue(FLT, 24, 2, 3, 1, 0, 0, 0, 1, 4, 6, "R9");
      idle(10);
      issue(FDIV, 25, 4, 9, 9, 0, 0, 0, 1, 6, 4, "R9");
      issue(FLT, 26, 1, 1, 1, 0, 0, 0, 0, 4, 0, "R9");
      idle(8);

      // R10: back-pressure through the floating pipe
      issue(FLT, 27, 1, 1, 5, 0, 0, 0, 1, 4, 7, "R10");
      issue(FLT, 28, 1, 2, 1, 0, 0, 0, 0, 4, 0, "R10");
      issue(FLT, 28, 1, 2, 1, 0, 0, 0, 1, 4, 6, "R10");
      issue(FLT, 29, 1, 1, 1, 0, 0, 0, 0, 4, 0, "R10");
      issue(FLT, 29, 1, 1, 1, 0, 0, 0, 1, 4, 5, "R10");
      idle(12);

      // R11: load/store pipe, free and blocked
      issue(MEM, 30, 2, 3, 0, 0, 0, 0, 1, 3, 5, "R11");
      idle(8);
      issue(MEM, 31, 1, 4, 0, 0, 0, 0, 1, 3, 5, "R11");
      issue(MEM, 32, 1, 1, 0, 0, 0, 0, 0, 3, 0, "R11");
      issue(MEM, 32, 1, 1, 0, 0, 0, 0, 1, 3, 4, "R11");
      idle(10);

      vectors++;
      if (sb.size() != 0) begin
         miscompares++;
         $display("FAIL R12: %0d completions outstanding, expected 0", sb.size());
      end
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule